// File: doc/BRIEF.md
# Address-Mapped Pin Expander with Edge Interrupts

This block is a sixteen-pin expander that a host reaches through a small register file. It uses a write strobe, an address and write data, and the read data is decoded from the address. For each pin the host sets a direction bit and an output level, and it can read the pin's level after that level has passed through a two-stage synchronizer. Ordinary pins can drive things such as reset lines for a disc loader or a modem processor.

Four pins are fixed as interrupt sources, for example a remote-control receiver or a request line from a modem processor. Each source has its own enable bit and its own edge choice, rising or falling. A qualifying edge sets a sticky status bit. The status bit stays set until the host writes a 1 to it.

One further pin carries the combined interrupt back to the host. The signal is active-low. The pin pulls low while any enabled status bit is set. At all other times it behaves like an ordinary pin.

Top module: `pin_expander`

## Requirements
- R1: After reset every pin is an input (`pin_oe`=0) and every output level is 0. The direction (addr 0), output (addr 1), interrupt config (addr 3) and status (addr 4) registers all read 0.
- R2: A write to addr 0 sets the direction bits (1 = drive) and a write to addr 1 sets the output levels. Both read back unchanged. While no interrupt is pending, they appear on `pin_oe` and `pin_out`.
- R3: Reading addr 2 returns `pin_in` through a two-flop synchronizer. A change at the pins is still invisible after one clock edge and is visible after the second.
- R4: The interrupt sources are pins 9, 12, 14 and 15, as sources 0 to 3. Addr 3 holds the per-source enables in bits 3:0 and the edge selects in bits 7:4, where 0 means rising and 1 means falling. With an enable set and select 0, a rising edge sets status bit i (addr 4, bit i) and a falling edge does not.
- R5: With an enable set and select 1, a falling edge sets the status bit and a rising edge does not.
- R6: A source whose enable bit is 0 never sets its status bit, whichever edge arrives.
- R7: A status bit stays set until a write to addr 4 with that bit at 1. Writing 0 to that bit, or writing 1 only to other bits, leaves it set.
- R8: When a qualifying edge and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R9: Pin 11 is the interrupt output. While any enabled status bit is set, `pin_oe[11]`=1 and `pin_out[11]`=0, overriding the registers. In the cycle after the last set bit is cleared, pin 11 returns to its direction and output register values.
- R10: Edges on pins that are not interrupt sources never set any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output levels to the pads |
| pin_oe | output | 16 | Drive enables to the pads (1 = drive) |

## Verification
The hardest case to reach from the ports is an edge and a clearing write landing on one status bit in the same cycle. The edge only shows up in the status logic three clock edges after the pin moves. The bench therefore first sets the bit, then returns the pin to its idle level. It then moves the pin again and holds the write strobe back for exactly two clock edges, so that the clear meets the edge. Random trials choose the source, the enable, the edge select and the starting level, and compare the status bit and interrupt pin against a model in the bench.

// File: rtl/pin_expander_pkg.sv
package pin_expander_pkg;
   typedef enum logic [2:0] {
      RA_DIR  = 3'd0,
      RA_OUT  = 3'd1,
      RA_IN   = 3'd2,
      RA_CFG  = 3'd3,
      RA_STAT = 3'd4
   } reg_addr_e;

   localparam int REG_ADDR_W = 3;
endpackage

// File: rtl/pin_expander_sync.sv
module pin_expander_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_expander_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            chain[k] <= chain[k-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_expander_edge.sv
module pin_expander_edge #(
   parameter int N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lvl,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] fall_sel,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] stat,
   output logic             pending
);
   logic [N_SRC-1:0] prev;
   logic [N_SRC-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = en[i] & (fall_sel[i] ? (prev[i] & ~lvl[i]) : (lvl[i] & ~prev[i]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= hit[i] | (stat[i] & ~clr[i]);
      end

      // R7: sticky without a clear
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         stat[i] && !clr[i] |=> stat[i]);
      // R7: clear without a new edge empties the bit
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && !hit[i] |=> !stat[i]);
      // R8: edge beats clear
      p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && hit[i] |=> stat[i]);
      // R6: a bit only rises while its source is enabled
      p_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat[i]) |-> $past(en[i]));
   end

   assign pending = |(stat & en);
endmodule

// File: rtl/pin_expander_regs.sv
module pin_expander_regs
   import pin_expander_pkg::*;
#(
   parameter int N_PINS = 16,
   parameter int N_SRC  = 4,
   parameter int DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [N_PINS-1:0]     in_sync,
   input  logic [N_SRC-1:0]      stat,
   output logic [N_PINS-1:0]     dir,
   output logic [N_PINS-1:0]     dout,
   output logic [N_SRC-1:0]      irq_en,
   output logic [N_SRC-1:0]      irq_fall,
   output logic [N_SRC-1:0]      clr,
   output logic [DATA_W-1:0]     rdata
);
   localparam int CFG_W = 2 * N_SRC;

   if (DATA_W < N_PINS || DATA_W < CFG_W) begin : g_bad_width
      $error("pin_expander_regs: DATA_W too narrow");
   end

   logic wr_dir, wr_out, wr_cfg;

   assign wr_dir = wr_en && (addr == RA_DIR);
   assign wr_out = wr_en && (addr == RA_OUT);
   assign wr_cfg = wr_en && (addr == RA_CFG);
   assign clr    = (wr_en && (addr == RA_STAT)) ? wdata[N_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir      <= '0;
         dout     <= '0;
         irq_en   <= '0;
         irq_fall <= '0;
      end else begin
         if (wr_dir) dir  <= wdata[N_PINS-1:0];
         if (wr_out) dout <= wdata[N_PINS-1:0];
         if (wr_cfg) begin
            irq_en   <= wdata[N_SRC-1:0];
            irq_fall <= wdata[CFG_W-1:N_SRC];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_DIR:  rdata[N_PINS-1:0] = dir;
         RA_OUT:  rdata[N_PINS-1:0] = dout;
         RA_IN:   rdata[N_PINS-1:0] = in_sync;
         RA_CFG:  rdata[CFG_W-1:0]  = {irq_fall, irq_en};
         RA_STAT: rdata[N_SRC-1:0]  = stat;
         default: rdata = '0;
      endcase
   end

   // R2: a direction write lands in the register on the next cycle
   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir == $past(wdata[N_PINS-1:0]));
   // R2: output levels hold when no write targets them
   p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> $stable(dout));
endmodule

// File: rtl/pin_expander.sv
module pin_expander
   import pin_expander_pkg::*;
#(
   parameter int N_PINS      = 16,
   parameter int N_SRC       = 4,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = $clog2(N_PINS),
   parameter logic [N_SRC*SEL_W-1:0] SRC_MAP = 16'hFEC9,
   parameter int IRQ_PIN     = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   input  logic [N_PINS-1:0]     pin_in,
   output logic [N_PINS-1:0]     pin_out,
   output logic [N_PINS-1:0]     pin_oe
);
   if (IRQ_PIN >= N_PINS) begin : g_bad_irq_pin
      $error("pin_expander: IRQ_PIN out of range");
   end

   logic [N_PINS-1:0] in_sync;
   logic [N_PINS-1:0] dir, dout;
   logic [N_SRC-1:0]  src_lvl, irq_en, irq_fall, clr, stat;
   logic              pending;

   pin_expander_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_map
      localparam int P = int'(SRC_MAP[i*SEL_W +: SEL_W]);
      if (P >= N_PINS || P == IRQ_PIN) begin : g_bad_map
         $error("pin_expander: bad interrupt source pin");
      end
      assign src_lvl[i] = in_sync[P];
   end

   pin_expander_regs #(.N_PINS(N_PINS), .N_SRC(N_SRC), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .in_sync(in_sync), .stat(stat), .dir(dir), .dout(dout),
      .irq_en(irq_en), .irq_fall(irq_fall), .clr(clr), .rdata(rdata)
   );

   pin_expander_edge #(.N_SRC(N_SRC)) i_edge (
      .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .en(irq_en), .fall_sel(irq_fall),
      .clr(clr), .stat(stat), .pending(pending)
   );

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      if (p == IRQ_PIN) begin : g_irq
         assign pin_oe[p]  = pending | dir[p];
         assign pin_out[p] = pending ? 1'b0 : dout[p];
      end else begin : g_gpio
         assign pin_oe[p]  = dir[p];
         assign pin_out[p] = dout[p];
      end
   end

   // R9: a new status bit on an enabled source pulls the interrupt pin low
   p_irq_on_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|(stat & irq_en)) |-> pin_oe[IRQ_PIN] && !pin_out[IRQ_PIN]);
endmodule

// File: tb/test_pin_expander.sv
module test_pin_expander;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;
   localparam int SRC_PIN[4] = '{9, 12, 14, 15};
   localparam int IRQP = 11;

   always #5 clk = ~clk;

   pin_expander i_pin_expander (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   function automatic bit exp_hit(bit en, bit fall, bit from, bit to);
      if (!en || from == to) return 1'b0;
      return fall ? (from && !to) : (!from && to);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] v, d, o, old;
      void'($urandom(32'h5eed_0042));
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 pin_out", pin_out, 0);
      rd(3'd0, v); chk("R1 dir", v, 0);
      rd(3'd1, v); chk("R1 out", v, 0);
      rd(3'd3, v); chk("R1 cfg", v, 0);
      rd(3'd4, v); chk("R1 stat", v, 0);

      // R2 direction/output registers
      for (int n = 0; n < 10; n++) begin
         d = 16'($urandom); o = 16'($urandom);
         @(negedge clk);
         wr(3'd0, d); wr(3'd1, o);
         rd(3'd0, v); chk("R2 dir readback", v, d);
         rd(3'd1, v); chk("R2 out readback", v, o);
         chk("R2 pin_oe", pin_oe, d);
         chk("R2 pin_out", pin_out, o);
      end
      wr(3'd0, 16'h0); wr(3'd1, 16'h0);

      // R3 synchronized input read
      old = 16'h0;
      for (int n = 0; n < 10; n++) begin
         v = 16'($urandom);
         pin_in = v;
         @(negedge clk);
         rd(3'd2, d); chk("R3 after one edge", d, old);
         @(negedge clk);
         rd(3'd2, d); chk("R3 after two edges", d, v);
         old = v;
      end
      pin_in = '0;
      idle(4);

      // R4/R5/R6/R9 random edge trials
      for (int n = 0; n < 40; n++) begin
         int s;
         bit en, fl, from, h;
         s = int'($urandom % 4);
         en = 1'($urandom); fl = 1'($urandom); from = 1'($urandom);
         @(negedge clk);
         wr(3'd3, 16'((32'(en) << s) | (32'(fl) << (4 + s))));
         pin_in[SRC_PIN[s]] = from;
         idle(4);
         wr(3'd4, 16'hF);
         pin_in[SRC_PIN[s]] = ~from;
         idle(3);
         h = exp_hit(en, fl, from, ~from);
         rd(3'd4, v);
         if (!en)      chk("R6 disabled source", v, 0);
         else if (fl)  chk("R5 falling select", v, 16'(32'(h) << s));
         else          chk("R4 rising select", v, 16'(32'(h) << s));
         chk("R9 irq drive", pin_oe[IRQP], h);
         chk("R9 irq level", pin_out[IRQP], 0);
      end
      pin_in = '0;
      idle(4);
      wr(3'd4, 16'hF);

      // R10 non-source pin edges ignored
      wr(3'd3, 16'h000F);
      pin_in[5] = 1'b1; pin_in[3] = 1'b1;
      idle(4);
      rd(3'd4, v); chk("R10 non-source pins", v, 0);
      chk("R10 irq idle", pin_oe[IRQP], 0);

      // R7 sticky + R9 override and release
      wr(3'd0, 16'h0800); wr(3'd1, 16'h0800);
      chk("R9 pin11 as gpio", {pin_oe[IRQP], pin_out[IRQP]}, 2'b11);
      pin_in[12] = 1'b1;
      idle(3);
      rd(3'd4, v); chk("R7 bit set", v, 16'h0002);
      chk("R9 override low", {pin_oe[IRQP], pin_out[IRQP]}, 2'b10);
      wr(3'd4, 16'h0000);
      rd(3'd4, v); chk("R7 write zero keeps", v, 16'h0002);
      wr(3'd4, 16'h0001);
      idle(5);
      rd(3'd4, v); chk("R7 other bit write keeps", v, 16'h0002);
      wr(3'd4, 16'h0002);
      rd(3'd4, v); chk("R7 cleared", v, 0);
      chk("R9 released next cycle", {pin_oe[IRQP], pin_out[IRQP]}, 2'b11);
      wr(3'd0, 16'h0); wr(3'd1, 16'h0);

      // R8 edge and clear collide
      pin_in[12] = 1'b0;
      idle(4);
      pin_in[12] = 1'b1;
      idle(3);
      rd(3'd4, v); chk("R8 setup set", v, 16'h0002);
      pin_in[12] = 1'b0;
      idle(4);
      pin_in[12] = 1'b1;
      idle(2);
      wr(3'd4, 16'h0002);
      rd(3'd4, v); chk("R8 edge wins over clear", v, 16'h0002);
      wr(3'd4, 16'h0002);
      rd(3'd4, v); chk("R8 later clear", v, 0);

      finish_run();
   end
endmodule